// File: doc/BRIEF.md
# Interrupt Capture and Exception Redirect Coprocessor

This block is the system-control coprocessor for a small five-stage integer core. It watches a set of external interrupt request lines (three by default), holds each rising request in a pending bit, and raises a take signal when global interrupts are on and at least one pending source is unmasked. In the cycle the take signal is high, the core is sent to the fixed handler address 0x00000800. At the next clock edge the block saves the core's resume address into the exception PC register, clears the global enable bit and records which source was taken.

Software reaches the block's registers with move-from and move-to operations, selected by a 5-bit register index. An exception-return input sends the core back to the saved address and turns global interrupts on again. Nesting is left to the handler. It saves the exception PC, acknowledges its source, and sets the enable bit again so that a further source can be taken. Later it restores the exception PC by writing it back.

Top module: `sysctl_cop`

## Requirements
- R1: After a synchronous active-low reset, the status (index 12), cause (index 13) and exception PC (index 14) registers read as zero, and `exc_take` is low.
- R2: A low-to-high change on `irq_in[i]` sets pending bit i at the clock edge where the high level is first sampled. Pending bit i reads as cause bit 8+i. A request line that simply stays high does not set the bit again after it is cleared.
- R3: `exc_take` is high while status bit 0 (global enable) is 1 and some pending bit i has its mask bit (status bit i+1) at 1. While `exc_take` is high, `redirect_valid` is 1 and `redirect_pc` is 0x00000800.
- R4: At the clock edge that ends an `exc_take` cycle, the exception PC takes the value of `pc_in`, status bit 0 clears, and cause bits [1:0] take the number of the source that was taken.
- R5: When several unmasked sources are pending, the lowest-numbered one is taken.
- R6: A move-to of cause clears each pending bit i that has a 1 written in data bit 8+i. If a new rising edge arrives in the same cycle, the bit is set instead.
- R7: A move-to of status writes bits [3:0]. A move-to of the exception PC writes all 32 bits. A move-from returns each register as described in R1 to R6, and all other status bits read as zero.
- R8: When `eret_in` is high and no take is active, `redirect_valid` is 1 and `redirect_pc` equals the exception PC. Status bit 0 is set at the next edge.
- R9: A move-to or `eret_in` presented in a cycle where `exc_take` is high has no effect on status, cause or the exception PC.
- R10: A pending source that is masked, or blocked by a clear enable bit, stays pending with no take. It is taken as soon as software unmasks it or sets the enable bit, including from inside a handler.
- R11: Register indices other than 12, 13 and 14 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 3 | Interrupt request lines, edge captured |
| pc_in | input | 32 | Resume address that is saved when an exception is taken |
| mf_idx | input | 5 | Register index for a move-from read |
| mf_data | output | 32 | Read data for `mf_idx` (combinational) |
| mt_en | input | 1 | Move-to write strobe |
| mt_idx | input | 5 | Register index for a move-to write |
| mt_data | input | 32 | Move-to write data |
| eret_in | input | 1 | Exception-return request |
| exc_take | output | 1 | An exception is being taken in this cycle |
| redirect_valid | output | 1 | The core must load `redirect_pc` as its next PC |
| redirect_pc | output | 32 | Handler vector or saved return address |

## Verification
An edge on a request line shows in the pending bits one clock edge after it is driven. A take follows in that same cycle, with no further register on the path. The saved PC, the cleared enable bit and the cause code appear one edge after the take cycle. Register writes and the enable set by a return also appear one edge later. Reads and redirects are combinational. The bench drives every input on the falling edge and samples a short delay after a falling edge, counting registers to choose which falling edge. Take and redirect are checked in the cycle the stimulus is applied, and register effects in the cycle that follows.

// File: rtl/sysctl_pkg.sv
// Package: shared widths, register indices and bit positions for the
// system-control coprocessor. Assumes a 32-bit datapath and 5-bit indices.
package sysctl_pkg;
    localparam int XLEN      = 32;
    localparam int IDX_W     = 5;
    localparam int PEND_LSB  = 8;
    localparam logic [IDX_W-1:0] IDX_STATUS = 5'd12;
    localparam logic [IDX_W-1:0] IDX_CAUSE  = 5'd13;
    localparam logic [IDX_W-1:0] IDX_EPC    = 5'd14;
    localparam logic [XLEN-1:0]  VECTOR_PC  = 32'h0000_0800;
endpackage

// File: rtl/sysctl_irq_capture.sv
// Module: edge capture of the request lines into pending bits.
// Assumes the request lines are already synchronous to clk. A rising edge
// sets its pending bit. A write-one-to-clear vector clears it, and an edge
// in the same cycle wins over the clear.
module sysctl_irq_capture #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);
    logic [NUM_SRC-1:0] irq_q;
    logic [NUM_SRC-1:0] rise;

    // Sample request lines to find rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq;
    end

    assign rise = irq & ~irq_q;

    // Per-source pending bit: set on edge, clear on acknowledge
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            always_ff @(posedge clk) begin
                if (!rst_n)       pend[i] <= 1'b0;
                else if (rise[i]) pend[i] <= 1'b1;
                else if (clr[i])  pend[i] <= 1'b0;
            end

            assert_pend_set_R2 : assert property (@(posedge clk) disable iff (!rst_n)
                rise[i] |=> pend[i]);
            assert_pend_clr_R6 : assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !rise[i]) |=> !pend[i]);
        end
    endgenerate
endmodule

// File: rtl/sysctl_prio.sv
// Module: fixed-priority selector. Among the requests, the lowest index
// wins. Purely combinational; gives a one-hot grant and its index.
module sysctl_prio #(
    parameter int NUM_SRC = 3,
    localparam int ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [ID_W-1:0]    id,
    output logic [NUM_SRC-1:0] grant
);
    // Scan from the top down so the lowest set request is the last one kept
    always_comb begin
        any   = |req;
        id    = '0;
        grant = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                id       = ID_W'(i);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    always_comb begin
        assert_grant_onehot_R5 : assert ($onehot0(grant));
        if (any) assert_grant_lowest_R5 : assert (((grant - 1'b1) & req) == '0);
    end
endmodule

// File: rtl/sysctl_cop.sv
// Module: system-control coprocessor top. Holds status (enable and masks),
// cause (pending bits and taken-source code) and the exception PC. It raises
// a take toward the handler vector and redirects to the saved PC on return.
// Assumes the core squashes the instruction in a take cycle, so a move-to or
// return presented in that cycle is dropped.
module sysctl_cop
    import sysctl_pkg::*;
#(
    parameter int NUM_SRC = 3,
    localparam int ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [XLEN-1:0]    pc_in,
    input  logic [IDX_W-1:0]   mf_idx,
    output logic [XLEN-1:0]    mf_data,
    input  logic               mt_en,
    input  logic [IDX_W-1:0]   mt_idx,
    input  logic [XLEN-1:0]    mt_data,
    input  logic               eret_in,
    output logic               exc_take,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc
);
    logic               ie_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [XLEN-1:0]    epc_q;
    logic [ID_W-1:0]    code_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ack;
    logic [NUM_SRC-1:0] grant;
    logic               any_req;
    logic [ID_W-1:0]    sel_id;

    // Acknowledge vector from a cause write, dropped in a take cycle
    assign ack = (mt_en && mt_idx == IDX_CAUSE && !exc_take)
                 ? mt_data[PEND_LSB +: NUM_SRC] : '0;

    sysctl_irq_capture #(.NUM_SRC(NUM_SRC)) u_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .irq  (irq_in),
        .clr  (ack),
        .pend (pend)
    );

    sysctl_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .req  (pend & mask_q),
        .any  (any_req),
        .id   (sel_id),
        .grant(grant)
    );

    assign exc_take       = ie_q && any_req;
    assign redirect_valid = exc_take || eret_in;
    assign redirect_pc    = exc_take ? VECTOR_PC : epc_q;

    // Control register update: take first, then return and software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            mask_q <= '0;
            epc_q  <= '0;
            code_q <= '0;
        end else if (exc_take) begin
            epc_q  <= pc_in;
            ie_q   <= 1'b0;
            code_q <= sel_id;
        end else begin
            if (eret_in) ie_q <= 1'b1;
            if (mt_en && mt_idx == IDX_STATUS) {mask_q, ie_q} <= mt_data[NUM_SRC:0];
            if (mt_en && mt_idx == IDX_EPC)    epc_q <= mt_data;
        end
    end

    // Move-from read mux; unmapped indices return zero
    always_comb begin
        mf_data = '0;
        case (mf_idx)
            IDX_STATUS: mf_data[NUM_SRC:0] = {mask_q, ie_q};
            IDX_CAUSE: begin
                mf_data[PEND_LSB +: NUM_SRC] = pend;
                mf_data[ID_W-1:0]            = code_q;
            end
            IDX_EPC:    mf_data = epc_q;
            default:    mf_data = '0;
        endcase
    end

    assert_take_saves_pc_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (epc_q == $past(pc_in)) && !ie_q);
    assert_take_code_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> code_q == $past(sel_id));
    assert_take_masked_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> ((grant & pend & mask_q) != '0));
    assert_eret_enables_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (eret_in && !exc_take && !(mt_en && mt_idx == IDX_STATUS)) |=> ie_q);
endmodule

// File: tb/sysctl_cop_test.sv
// Directed bench for the coprocessor: one task for each scenario. Inputs
// change on the falling edge and outputs are read 1 time unit after it.
module sysctl_cop_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  irq_in;
    logic [31:0] pc_in;
    logic [4:0]  mf_idx;
    logic [31:0] mf_data;
    logic        mt_en;
    logic [4:0]  mt_idx;
    logic [31:0] mt_data;
    logic        eret_in;
    logic        exc_take;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_cop uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pc_in(pc_in),
        .mf_idx(mf_idx), .mf_data(mf_data), .mt_en(mt_en), .mt_idx(mt_idx),
        .mt_data(mt_data), .eret_in(eret_in), .exc_take(exc_take),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [4:0] idx, output logic [31:0] val);
        mf_idx = idx;
        #1;
        val = mf_data;
    endtask

    // One write cycle: strobe between two falling edges
    task automatic wr(input logic [4:0] idx, input logic [31:0] val);
        @(negedge clk);
        mt_en = 1'b1; mt_idx = idx; mt_data = val;
        @(negedge clk);
        mt_en = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst_n = 1'b0; irq_in = '0; pc_in = '0; mf_idx = '0;
        mt_en = 1'b0; mt_idx = '0; mt_data = '0; eret_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        rd(5'd12, v); chk("R1 status", v, 32'h0);
        rd(5'd13, v); chk("R1 cause", v, 32'h0);
        rd(5'd14, v); chk("R1 epc", v, 32'h0);
        chk("R1 take", {31'd0, exc_take}, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        wr(5'd12, 32'h3);
        @(negedge clk);
        irq_in = 3'b001; pc_in = 32'h0000_1234;
        @(negedge clk); #1;
        chk("R3 take", {31'd0, exc_take}, 32'h1);
        chk("R3 redirect valid", {31'd0, redirect_valid}, 32'h1);
        chk("R3 vector", redirect_pc, 32'h0000_0800);
        @(negedge clk); #1;
        chk("R4 take drops", {31'd0, exc_take}, 32'h0);
        rd(5'd14, v); chk("R4 epc", v, 32'h0000_1234);
        rd(5'd12, v); chk("R4 ie cleared", v, 32'h2);
        rd(5'd13, v); chk("R2 R4 cause", v, 32'h100);
        wr(5'd13, 32'h100);
        rd(5'd13, v); chk("R6 ack", v, 32'h0);
        @(negedge clk); #1;
        rd(5'd13, v); chk("R2 held level no reset", v, 32'h0);
        irq_in = '0;
    endtask

    task automatic t_priority_nest();
        logic [31:0] v;
        wr(5'd12, 32'he);
        @(negedge clk);
        irq_in = 3'b110; pc_in = 32'h0000_2000;
        @(negedge clk); #1;
        rd(5'd13, v); chk("R10 pending no take", v, 32'h600);
        chk("R10 no take when disabled", {31'd0, exc_take}, 32'h0);
        wr(5'd12, 32'hf);
        chk("R5 take", {31'd0, exc_take}, 32'h1);
        @(negedge clk); #1;
        rd(5'd13, v); chk("R5 lowest source", v, 32'h601);
        wr(5'd13, 32'h200);
        rd(5'd13, v); chk("R6 ack src1", v, 32'h401);
        pc_in = 32'h0000_0804;
        wr(5'd12, 32'hf);
        chk("R10 nested take", {31'd0, exc_take}, 32'h1);
        @(negedge clk); #1;
        rd(5'd13, v); chk("R10 nested code", v, 32'h402);
        rd(5'd14, v); chk("R10 nested epc", v, 32'h0000_0804);
        wr(5'd13, 32'h400);
        irq_in = '0;
        wr(5'd14, 32'h0000_2000);
        rd(5'd14, v); chk("R7 epc write", v, 32'h0000_2000);
    endtask

    task automatic t_eret();
        logic [31:0] v;
        @(negedge clk);
        eret_in = 1'b1;
        #1;
        chk("R8 redirect valid", {31'd0, redirect_valid}, 32'h1);
        chk("R8 return pc", redirect_pc, 32'h0000_2000);
        chk("R8 no take", {31'd0, exc_take}, 32'h0);
        @(negedge clk);
        eret_in = 1'b0;
        #1;
        rd(5'd12, v); chk("R8 ie set", v, 32'hf);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(5'd12, 32'h9);
        @(negedge clk);
        irq_in = 3'b001; pc_in = 32'h0000_3000;
        @(negedge clk); #1;
        chk("R10 masked no take", {31'd0, exc_take}, 32'h0);
        rd(5'd13, v); chk("R10 masked pending", v, 32'h102);
        wr(5'd12, 32'hb);
        chk("R10 unmask take", {31'd0, exc_take}, 32'h1);
        @(negedge clk); #1;
        rd(5'd13, v); chk("R4 code src0", v, 32'h100);
        rd(5'd14, v); chk("R4 epc src0", v, 32'h0000_3000);
        // rising edge and acknowledge in the same cycle: edge wins
        irq_in = '0;
        @(negedge clk);
        irq_in = 3'b001; mt_en = 1'b1; mt_idx = 5'd13; mt_data = 32'h100;
        @(negedge clk);
        mt_en = 1'b0; #1;
        rd(5'd13, v); chk("R6 set wins", v, 32'h100);
        wr(5'd13, 32'h100);
        irq_in = '0;
    endtask

    task automatic t_conflict();
        logic [31:0] v;
        wr(5'd12, 32'h5);
        @(negedge clk);
        irq_in = 3'b010; pc_in = 32'h0000_4000;
        @(negedge clk);
        eret_in = 1'b1; mt_en = 1'b1; mt_idx = 5'd14; mt_data = 32'hdead_beef;
        #1;
        chk("R9 take active", {31'd0, exc_take}, 32'h1);
        chk("R9 take beats eret", redirect_pc, 32'h0000_0800);
        @(negedge clk);
        eret_in = 1'b0; mt_en = 1'b0; #1;
        rd(5'd14, v); chk("R9 epc write dropped", v, 32'h0000_4000);
        rd(5'd12, v); chk("R9 eret dropped", v, 32'h4);
        wr(5'd13, 32'h200);
        irq_in = '0;
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(5'd5, 32'hffff_ffff);
        rd(5'd5, v); chk("R11 unmapped read", v, 32'h0);
        rd(5'd12, v); chk("R11 status untouched", v, 32'h4);
        wr(5'd12, 32'hffff_fff0);
        rd(5'd12, v); chk("R7 status width", v, 32'h0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_priority_nest();
        t_eret();
        t_mask();
        t_conflict();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule